// File: doc/BRIEF.md
# Compare-Gated Pulse Output Router

This block sits between two compare outputs of a timer, an external pulse-train generator and two output pins. It decides, cycle by cycle, which mix of compare levels and pulse train reaches each of the two waveform outputs. It also builds a gate signal that can start or hold the pulse-train generator. A 3-bit mode code picks the routing style. In pass mode the inputs go straight to the outputs. In compare-gated mode the pulse train is masked by the compare levels. In hold-gated mode the pulse train is masked by two internal hold flags. Each flag is raised by a rising edge of its compare input and held for a programmed number of cycles by one shared down-counter.

A 2-bit gate selector picks which sources feed the gate output. A 2-bit pulse selector picks, for each output separately, whether the pulse train is mixed in. The two dead-time mode codes are recognised, but this block only drives the gate output in those codes. It holds both waveform outputs low there. All control inputs are plain levels. The routing is combinational from the inputs and the hold flags, so a change on an input shows on the outputs in the same cycle. The flags and the counter are the only state.

Top module: `wave_route`

## Requirements
- R1: With mode code 000 (pass), `gate_out` is 0 whatever the other inputs are.
- R2: With mode code 000, `wave0` equals `pulse_in` when `pulse_sel[0]` is 1 and `cmp0` otherwise. `wave1` behaves the same way with `pulse_sel[1]` and `cmp1`.
- R3: With mode code 001 (compare-gated), `gate_out` follows the gate selector: 00 gives 0, 01 gives `cmp0`, 10 gives `cmp1`, 11 gives `cmp0 | cmp1`.
- R4: With mode code 001, `wave0` is `cmp0 & pulse_in` when `pulse_sel[0]` is 1 and `cmp0` otherwise. The same holds for `wave1` with `cmp1` and `pulse_sel[1]`.
- R5: With mode code 010 (hold-gated), a hold flag is raised at the clock edge where its compare input is 1 and was 0 at the previous edge. A compare input that is already high when the mode is entered raises nothing.
- R6: With mode code 010, `gate_out` uses the R3 encoding applied to hold flag 0 and hold flag 1. `waveN` is flag N when `pulse_sel[N]` is 0, and flag N `& pulse_in` when it is 1.
- R7: Raising a flag loads the shared counter from `hold_len`. The flags stay set for `hold_len`+1 cycles. Both flags then clear together at the edge where the counter is found at zero.
- R8: A rising edge on either compare input while a flag is already set reloads the counter. A flag raised earlier therefore stays set for longer than the programmed time.
- R9: Outside mode code 010, and during reset, both flags are held clear. Entering mode code 010 therefore starts with both waveform outputs low.
- R10: With mode code 111, `gate_out` follows the R3 encoding on the compare inputs. With mode code 100 and the unused codes 011, 101 and 110, `gate_out` is 0. In all of these codes both waveform outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Routing mode code |
| gate_sel | input | 2 | Gate source selector |
| pulse_sel | input | 2 | Per-output pulse-train mixing enable |
| hold_len | input | CNT_W | Reload value of the shared hold counter |
| cmp0 | input | 1 | Compare level 0 |
| cmp1 | input | 1 | Compare level 1 |
| pulse_in | input | 1 | External pulse train |
| wave0 | output | 1 | Waveform output 0 |
| wave1 | output | 1 | Waveform output 1 |
| gate_out | output | 1 | Gate for the pulse-train generator |

## Verification
A flag that is set when it should not be shows on the waveform output or the gate output in the same cycle, as long as the hold-gated mode routes that flag out. A stale copy of a compare input shows one cycle after the edge, as a missing or extra hold window. A counter that loads or counts wrongly shows only when the window closes, as a window that is one or more cycles too long or too short. The bench therefore measures whole window lengths, both with and without a retrigger, as well as checking each cycle.

// File: rtl/wave_route_pkg.sv
package wave_route_pkg;

  typedef enum logic [2:0] {
    MD_PASS    = 3'b000,
    MD_CMPGATE = 3'b001,
    MD_HOLD    = 3'b010,
    MD_RTDEAD  = 3'b100,
    MD_PGDEAD  = 3'b111
  } mode_e;

  // gate source encoding shared by compare-gated, hold-gated and pulse dead-time codes
  function automatic logic pick_gate(input logic [1:0] sel, input logic [1:0] src);
    logic r;
    case (sel)
      2'b00:   r = 1'b0;
      2'b01:   r = src[0];
      2'b10:   r = src[1];
      default: r = src[0] | src[1];
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rise_detect.sv
module rise_detect #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] lvl_q;

  for (genvar i = 0; i < N; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q[i] <= 1'b0;
      else        lvl_q[i] <= lvl[i];
    end
    assign rise[i] = lvl[i] & ~lvl_q[i];
  end
endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
  parameter int CNT_W = 16,
  parameter int N     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic [N-1:0]     rise,
  input  logic [CNT_W-1:0] reload,
  output logic [N-1:0]     flags,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      cnt   <= '0;
    end else if (!arm) begin
      flags <= '0;
      cnt   <= '0;
    end else if (|rise) begin
      flags <= flags | rise;
      cnt   <= reload;
    end else if (|flags) begin
      if (cnt == '0) flags <= '0;
      else           cnt   <= cnt - ONE;
    end
  end
endmodule

// File: rtl/route_mux.sv
module route_mux
  import wave_route_pkg::*;
#(
  parameter int N = 2
) (
  input  logic [2:0]   mode,
  input  logic [1:0]   gate_sel,
  input  logic [N-1:0] pulse_sel,
  input  logic [N-1:0] cmp,
  input  logic [N-1:0] flags,
  input  logic         pulse,
  output logic [N-1:0] wave,
  output logic         gate
);
  always_comb begin
    gate = 1'b0;
    wave = '0;
    case (mode)
      MD_PASS: begin
        for (int i = 0; i < N; i++) wave[i] = pulse_sel[i] ? pulse : cmp[i];
      end
      MD_CMPGATE: begin
        gate = pick_gate(gate_sel, cmp[1:0]);
        for (int i = 0; i < N; i++) wave[i] = cmp[i] & (pulse | ~pulse_sel[i]);
      end
      MD_HOLD: begin
        gate = pick_gate(gate_sel, flags[1:0]);
        for (int i = 0; i < N; i++) wave[i] = flags[i] & (pulse | ~pulse_sel[i]);
      end
      MD_PGDEAD: gate = pick_gate(gate_sel, cmp[1:0]);
      default: ;
    endcase
  end
endmodule

// File: rtl/wave_route.sv
module wave_route
  import wave_route_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode,
  input  logic [1:0]       gate_sel,
  input  logic [1:0]       pulse_sel,
  input  logic [CNT_W-1:0] hold_len,
  input  logic             cmp0,
  input  logic             cmp1,
  input  logic             pulse_in,
  output logic             wave0,
  output logic             wave1,
  output logic             gate_out
);
  localparam int NCH = 2;

  logic [NCH-1:0]   cmp_v;
  logic [NCH-1:0]   rise_w;
  logic [NCH-1:0]   flag_w;
  logic [NCH-1:0]   wave_v;
  logic [CNT_W-1:0] cnt_w;
  logic             hold_mode;

  assign cmp_v     = {cmp1, cmp0};
  assign hold_mode = (mode == MD_HOLD);

  rise_detect #(.N(NCH)) u_rise (
    .clk(clk), .rst_n(rst_n), .lvl(cmp_v), .rise(rise_w)
  );

  hold_timer #(.CNT_W(CNT_W), .N(NCH)) u_timer (
    .clk(clk), .rst_n(rst_n), .arm(hold_mode), .rise(rise_w),
    .reload(hold_len), .flags(flag_w), .cnt(cnt_w)
  );

  route_mux #(.N(NCH)) u_mux (
    .mode(mode), .gate_sel(gate_sel), .pulse_sel(pulse_sel), .cmp(cmp_v),
    .flags(flag_w), .pulse(pulse_in), .wave(wave_v), .gate(gate_out)
  );

  assign wave0 = wave_v[0];
  assign wave1 = wave_v[1];
endmodule

// File: rtl/wave_route_chk.sv
module wave_route_chk
  import wave_route_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       mode,
  input logic             cmp0,
  input logic             wave0,
  input logic             gate_out,
  input logic [1:0]       rise,
  input logic [1:0]       flags,
  input logic [CNT_W-1:0] cnt
);
  AST_PASS_GATE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_PASS) |-> !gate_out); // R1

  AST_CMPGATE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_CMPGATE && !cmp0) |-> !wave0); // R4

  AST_EDGE_RAISES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_HOLD && rise[0]) |=> flags[0]); // R5

  AST_HOLD_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_HOLD && !flags[0]) |-> !wave0); // R6

  AST_EXPIRY_CLEARS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_HOLD && (|flags) && cnt == '0 && !(|rise)) |=> (flags == 2'b00)); // R7

  AST_RETRIGGER_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_HOLD && flags[0] && rise[1]) |=> flags[0]); // R8

  AST_FLAGS_CLEAR_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MD_HOLD) |=> (flags == 2'b00)); // R9
endmodule

bind wave_route wave_route_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .cmp0(cmp0), .wave0(wave0),
  .gate_out(gate_out), .rise(rise_w), .flags(flag_w), .cnt(cnt_w)
);

// File: tb/test_wave_route.sv
`timescale 1ns/1ps
module test_wave_route;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] mode = 3'b010;
  logic [1:0] gsel = 2'b11, psel = 2'b11;
  logic [CW-1:0] hlen = '0;
  logic c0 = 1'b0, c1 = 1'b0, pp = 1'b0;
  logic w0, w1, g;

  // next configuration, applied inside step at the falling edge
  logic nrst = 1'b0;
  logic [2:0] nm = 3'b010;
  logic [1:0] ng = 2'b11, np = 2'b11;
  logic [CW-1:0] nh = '0;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  bit q0, q1, f0, f1;
  int cnt;
  logic s_w0, s_w1, s_g;

  always #2 clk = ~clk;

  wave_route #(.CNT_W(CW)) i_wave_route (
    .clk(clk), .rst_n(rst_n), .mode(mode), .gate_sel(gsel), .pulse_sel(psel),
    .hold_len(hlen), .cmp0(c0), .cmp1(c1), .pulse_in(pp),
    .wave0(w0), .wave1(w1), .gate_out(g)
  );

  task automatic chk1(string tag, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic chkn(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit sel_src(bit [1:0] e, bit a, bit b);
    case (e)
      2'd0: return 1'b0;
      2'd1: return a;
      2'd2: return b;
      default: return a | b;
    endcase
  endfunction

  task automatic model_check;
    bit eg, e0, e1;
    string tg, to;
    case (mode)
      3'b000: begin eg = 0; e0 = psel[0] ? pp : c0; e1 = psel[1] ? pp : c1; tg = "R1"; to = "R2"; end
      3'b001: begin eg = sel_src(gsel, c0, c1); e0 = c0 & (psel[0] ? pp : 1'b1);
                    e1 = c1 & (psel[1] ? pp : 1'b1); tg = "R3"; to = "R4"; end
      3'b010: begin eg = sel_src(gsel, f0, f1); e0 = f0 & (psel[0] ? pp : 1'b1);
                    e1 = f1 & (psel[1] ? pp : 1'b1); tg = "R6"; to = "R6"; end
      3'b111: begin eg = sel_src(gsel, c0, c1); e0 = 0; e1 = 0; tg = "R10"; to = "R10"; end
      default: begin eg = 0; e0 = 0; e1 = 0; tg = "R10"; to = "R10"; end
    endcase
    chk1({tg, " gate_out"}, g, eg);
    chk1({to, " wave0"}, w0, e0);
    chk1({to, " wave1"}, w1, e1);
  endtask

  task automatic model_tick;
    bit r0, r1;
    if (!rst_n) begin
      q0 = 0; q1 = 0; f0 = 0; f1 = 0; cnt = 0;
    end else begin
      r0 = c0 & !q0;
      r1 = c1 & !q1;
      if (mode != 3'b010) begin
        f0 = 0; f1 = 0; cnt = 0;
      end else if (r0 | r1) begin
        f0 = f0 | r0; f1 = f1 | r1; cnt = int'(hlen);
      end else if (f0 | f1) begin
        if (cnt == 0) begin f0 = 0; f1 = 0; end
        else cnt = cnt - 1;
      end
      q0 = c0; q1 = c1;
    end
  endtask

  task automatic step(input logic a, input logic b, input logic p);
    @(negedge clk);
    rst_n = nrst; mode = nm; gsel = ng; psel = np; hlen = nh;
    c0 = a; c1 = b; pp = p;
    #0.5;
    s_w0 = w0; s_w1 = w1; s_g = g;
    model_check;
    @(posedge clk);
    model_tick;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    logic a, b;
    void'($urandom(32'h1F2E3D4C));
    q0 = 0; q1 = 0; f0 = 0; f1 = 0; cnt = 0;

    // reset state: hold-gated mode with everything high, outputs stay low
    step(1, 1, 1);
    chk1("R9 reset outputs", s_w0 | s_w1 | s_g, 1'b0);
    step(1, 1, 1);
    nrst = 1'b1;

    // R7: window length without retrigger
    nm = 3'b010; ng = 2'b01; np = 2'b00; nh = CW'(5);
    repeat (8) step(0, 0, 0);
    step(1, 0, 0);
    n = 0;
    repeat (20) begin step(1, 0, 0); if (s_g) n++; end
    chkn("R7 hold window length", n, 6);

    // R7 with zero reload: one cycle
    nh = '0;
    step(0, 0, 0);
    step(1, 0, 0);
    n = 0;
    repeat (6) begin step(1, 0, 0); if (s_g) n++; end
    chkn("R7 zero reload window", n, 1);

    // R8: retrigger on the other input extends flag0
    nh = CW'(5);
    repeat (4) step(0, 0, 0);
    step(1, 0, 0);
    n = 0;
    repeat (2) begin step(1, 0, 0); if (s_g) n++; end
    step(1, 1, 0); if (s_g) n++;
    repeat (20) begin step(1, 1, 0); if (s_g) n++; end
    chkn("R8 retriggered window length", n, 9);

    // R9 / R5: entering hold mode with inputs already high
    nm = 3'b000; ng = 2'b11; np = 2'b00;
    repeat (3) step(1, 1, 0);
    nm = 3'b010;
    n = 0;
    repeat (10) begin step(1, 1, 0); if (s_g | s_w0 | s_w1) n++; end
    chkn("R9 entry with high inputs", n, 0);
    step(0, 1, 0);
    step(1, 1, 0);
    step(1, 1, 0);
    chk1("R5 wave0 after rise", s_w0, 1'b1);
    chk1("R5 wave1 without rise", s_w1, 1'b0);

    // R10: pulse dead-time code drives gate from compares only
    nm = 3'b111; ng = 2'b10; np = 2'b11;
    step(0, 1, 1);
    chk1("R10 gate from cmp1", s_g, 1'b1);
    chk1("R10 wave0 low", s_w0, 1'b0);

    // constrained random segments
    a = 0; b = 0;
    for (int seg = 0; seg < 48; seg++) begin
      nm = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 2) == 0) nm = 3'b010;
      ng = 2'($urandom_range(0, 3));
      np = 2'($urandom_range(0, 3));
      nh = CW'($urandom_range(0, 6));
      for (int k = 0; k < 30; k++) begin
        if ($urandom_range(0, 3) == 0) a = ~a;
        if ($urandom_range(0, 4) == 0) b = ~b;
        step(a, b, 1'($urandom_range(0, 1)));
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule